// File: doc/BRIEF.md
# I2C Master Repeated-START Generator

This block produces a repeated START condition on a pair of open-drain I2C lines on behalf of a bus master that already holds the bus. Software arms it with a one-cycle request strobe. The block then works through a fixed order of phases. It pulls the clock line low, releases the data line, releases the clock line, waits with both lines high, and finally pulls the data line low while the clock stays high. Each phase lasts one period of a down-counter that reloads from a programmable value. A phase only advances once the sampled line levels say the bus really is in the expected state.

Both lines are read back through a two-flop synchronizer. The block watches them for a START pattern and for two kinds of interference by another master. While a sequence runs, the block refuses new request strobes. Writes to the transmit byte register are also rejected, and each rejected write raises a write-collision flag. When the sequence completes, the block leaves the data line held low, ready for the first address byte. That byte is sent by other logic.

Top module: `i2cRestartGen`

## Requirements
- R1: A request strobe is accepted only when the block is idle and the `otherBusy` input is low; otherwise it has no effect (`reqBit` stays 0 and neither line is driven).
- R2: On acceptance, `sclDriveLow` goes to 1 at once. The period counter is loaded only on the clock edge after the synchronized SCL reads low (two synchronizer flops). A period lasts `reloadVal`+1 cycles.
- R3: During the clock-low phase SDA is released. SCL is released only once the period has ended and synchronized SDA reads high; while SDA is held low by the bus, SCL stays driven low.
- R4: The counter reloads when synchronized SCL first reads high, and both lines stay released for one further period.
- R5: SDA is then driven low for one period. With free lines, `doneFlag` rises 3·N+9 cycles after the accepting edge (N = `reloadVal`). At that point `reqBit` clears and `sdaDriveLow` stays 1 until the next accepted request releases SDA.
- R6: `startSeen` is set when synchronized SDA falls while synchronized SCL is high; with free lines this happens 2·N+11 cycles after the accepting edge. An accepted request clears `startSeen`, `doneFlag`, `collFlag` and `wrColl`.
- R7: A collision is detected if synchronized SDA is low on the edge where SCL is first seen high, or if synchronized SCL goes low during the both-high phase.
- R8: On a collision both lines are released, `collFlag` is set, `reqBit` clears, the block returns to idle and `doneFlag` stays 0.
- R9: A `bufWrite` while a sequence runs sets `wrColl` and leaves `bufData` unchanged; when idle, it stores `bufWData` on `bufData`.
- R10: Request strobes during a running sequence are ignored: the completion time is unchanged and no second sequence follows.
- R11: After reset, both drive outputs are 0 (lines released) and all flags and `reqBit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqWrite | input | 1 | One-cycle request strobe for a repeated START |
| otherBusy | input | 1 | Another bus event is in progress |
| bufWrite | input | 1 | Write strobe for the transmit byte |
| bufWData | input | DATA_W | Transmit byte write data |
| reloadVal | input | CNT_W | Period counter reload value |
| sdaIn | input | 1 | Raw SDA line level |
| sclIn | input | 1 | Raw SCL line level |
| sdaDriveLow | output | 1 | 1 pulls SDA low, 0 releases it |
| sclDriveLow | output | 1 | 1 pulls SCL low, 0 releases it |
| reqBit | output | 1 | Request bit, cleared by hardware |
| startSeen | output | 1 | START condition observed |
| doneFlag | output | 1 | Repeated START completed |
| collFlag | output | 1 | Bus collision detected |
| wrColl | output | 1 | Transmit write rejected |
| bufData | output | DATA_W | Transmit byte register |

## Verification
The assertions assume that `reloadVal` is held steady while a sequence runs. They also assume that the line inputs are the wired-AND of the block's own drives and any external pull-down, so a released line reads high only when nobody else pulls it. The bench builds each line exactly that way from the drive outputs and its own pull-down flags. It changes `reloadVal` only between sequences. It applies external pull-downs only at chosen phases, to stretch SDA, to force SCL low in the both-high window, or to pull SDA low under a stretched clock.

// File: rtl/i2cRsPkg.sv
package i2cRsPkg;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_SCL_LOW,
    RS_SDA_REL,
    RS_SCL_REL,
    RS_BOTH_HIGH,
    RS_SDA_LOW
  } rsState_e;

  typedef struct packed {
    logic accept;
    logic cntLoad;
    logic drvScl;
    logic drvSda;
    logic dropHold;
    logic finish;
    logic collide;
    logic busy;
  } rsStrobe_t;

endpackage

// File: rtl/i2cRsCtrl.sv
module i2cRsCtrl
  import i2cRsPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqWrite,
  input  logic      otherBusy,
  input  logic      sdaS,
  input  logic      sclS,
  input  logic      cntZero,
  output rsStrobe_t st
);

  rsState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= RS_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    st        = '0;
    st.busy   = (state != RS_IDLE);
    unique case (state)
      RS_IDLE: begin
        if (reqWrite && !otherBusy) begin
          st.accept = 1'b1;
          stateNext = RS_SCL_LOW;
        end
      end
      RS_SCL_LOW: begin
        st.drvScl = 1'b1;
        if (!sclS) begin
          st.cntLoad  = 1'b1;
          st.dropHold = 1'b1;
          stateNext   = RS_SDA_REL;
        end
      end
      RS_SDA_REL: begin
        st.drvScl = 1'b1;
        if (cntZero && sdaS) stateNext = RS_SCL_REL;
      end
      RS_SCL_REL: begin
        if (sclS) begin
          if (!sdaS) begin
            st.collide = 1'b1;
            stateNext  = RS_IDLE;
          end else begin
            st.cntLoad = 1'b1;
            stateNext  = RS_BOTH_HIGH;
          end
        end
      end
      RS_BOTH_HIGH: begin
        if (!sclS) begin
          st.collide = 1'b1;
          stateNext  = RS_IDLE;
        end else if (cntZero) begin
          st.cntLoad = 1'b1;
          stateNext  = RS_SDA_LOW;
        end
      end
      RS_SDA_LOW: begin
        st.drvSda = 1'b1;
        if (cntZero) begin
          st.finish = 1'b1;
          stateNext = RS_IDLE;
        end
      end
      default: stateNext = RS_IDLE;
    endcase
  end

  AST_ACCEPT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(st.busy) |-> $past(reqWrite && !otherBusy)); // R1

  AST_SCL_RELEASE_NEEDS_SDA: assert property (@(posedge clk) disable iff (!rstN)
    $fell(st.drvScl) |-> $past(sdaS) && $past(cntZero)); // R3

endmodule

// File: rtl/i2cRsDatapath.sv
module i2cRsDatapath
  import i2cRsPkg::*;
#(
  parameter int CNT_W       = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  rsStrobe_t         st,
  input  logic              bufWrite,
  input  logic [DATA_W-1:0] bufWData,
  input  logic [CNT_W-1:0]  reloadVal,
  input  logic              sdaIn,
  input  logic              sclIn,
  output logic              sdaS,
  output logic              sclS,
  output logic              cntZero,
  output logic              sdaDriveLow,
  output logic              sclDriveLow,
  output logic              reqBit,
  output logic              startSeen,
  output logic              doneFlag,
  output logic              collFlag,
  output logic              wrColl,
  output logic [DATA_W-1:0] bufData
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [SYNC_STAGES-1:0] sdaChain, sclChain;
  logic [CNT_W-1:0]       cnt;
  logic                   sdaPrev;
  logic                   holdSda;

  // two-or-more flop line synchronizers, reset to the idle-high bus level
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdaChain <= '1;
      sclChain <= '1;
      sdaPrev  <= 1'b1;
    end else begin
      sdaChain <= {sdaChain[SYNC_STAGES-2:0], sdaIn};
      sclChain <= {sclChain[SYNC_STAGES-2:0], sclIn};
      sdaPrev  <= sdaS;
    end
  end
  assign sdaS = sdaChain[SYNC_STAGES-1];
  assign sclS = sclChain[SYNC_STAGES-1];

  // period counter
  always_ff @(posedge clk) begin
    if (!rstN)             cnt <= '0;
    else if (st.cntLoad)   cnt <= reloadVal;
    else if (cnt != '0)    cnt <= cnt - CNT_ONE;
  end
  assign cntZero = (cnt == '0);

  // SDA kept low after completion until the next sequence releases it
  always_ff @(posedge clk) begin
    if (!rstN)                          holdSda <= 1'b0;
    else if (st.finish)                 holdSda <= 1'b1;
    else if (st.dropHold || st.collide) holdSda <= 1'b0;
  end

  assign sclDriveLow = st.drvScl;
  assign sdaDriveLow = st.drvSda | holdSda;

  // request bit and status flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqBit    <= 1'b0;
      startSeen <= 1'b0;
      doneFlag  <= 1'b0;
      collFlag  <= 1'b0;
      wrColl    <= 1'b0;
    end else begin
      if (st.accept) begin
        reqBit    <= 1'b1;
        startSeen <= 1'b0;
        doneFlag  <= 1'b0;
        collFlag  <= 1'b0;
        wrColl    <= 1'b0;
      end
      if (st.finish || st.collide) reqBit   <= 1'b0;
      if (st.finish)               doneFlag <= 1'b1;
      if (st.collide)              collFlag <= 1'b1;
      if (sdaPrev && !sdaS && sclS) startSeen <= 1'b1;
      if (bufWrite && st.busy)     wrColl   <= 1'b1;
    end
  end

  // transmit byte register, locked while a sequence runs
  always_ff @(posedge clk) begin
    if (!rstN)                     bufData <= '0;
    else if (bufWrite && !st.busy) bufData <= bufWData;
  end

  AST_DONE_HOLDS_SDA: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> sdaDriveLow && !reqBit && !collFlag); // R5

  AST_COLL_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    $rose(collFlag) |-> !sdaDriveLow && !sclDriveLow && !doneFlag && !reqBit); // R8

  AST_BUF_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (st.busy && bufWrite) |=> $stable(bufData) && wrColl); // R9

  AST_LOAD_AFTER_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (st.cntLoad && st.drvScl) |-> !sclS && $past(sclDriveLow)); // R2

endmodule

// File: rtl/i2cRestartGen.sv
module i2cRestartGen
  import i2cRsPkg::*;
#(
  parameter int CNT_W       = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqWrite,
  input  logic              otherBusy,
  input  logic              bufWrite,
  input  logic [DATA_W-1:0] bufWData,
  input  logic [CNT_W-1:0]  reloadVal,
  input  logic              sdaIn,
  input  logic              sclIn,
  output logic              sdaDriveLow,
  output logic              sclDriveLow,
  output logic              reqBit,
  output logic              startSeen,
  output logic              doneFlag,
  output logic              collFlag,
  output logic              wrColl,
  output logic [DATA_W-1:0] bufData
);

  rsStrobe_t st;
  logic      sdaS, sclS, cntZero;

  i2cRsCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqWrite  (reqWrite),
    .otherBusy (otherBusy),
    .sdaS      (sdaS),
    .sclS      (sclS),
    .cntZero   (cntZero),
    .st        (st)
  );

  i2cRsDatapath #(
    .CNT_W       (CNT_W),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .st          (st),
    .bufWrite    (bufWrite),
    .bufWData    (bufWData),
    .reloadVal   (reloadVal),
    .sdaIn       (sdaIn),
    .sclIn       (sclIn),
    .sdaS        (sdaS),
    .sclS        (sclS),
    .cntZero     (cntZero),
    .sdaDriveLow (sdaDriveLow),
    .sclDriveLow (sclDriveLow),
    .reqBit      (reqBit),
    .startSeen   (startSeen),
    .doneFlag    (doneFlag),
    .collFlag    (collFlag),
    .wrColl      (wrColl),
    .bufData     (bufData)
  );

endmodule

// File: tb/i2cRestartGen_tb.sv
`timescale 1ns/100ps
module i2cRestartGen_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqWrite = 1'b0, otherBusy = 1'b0, bufWrite = 1'b0;
  logic [7:0] bufWData = '0;
  logic [6:0] reloadVal = '0;
  logic       extSda = 1'b0, extScl = 1'b0;
  logic       sdaDriveLow, sclDriveLow, reqBit, startSeen, doneFlag, collFlag, wrColl;
  logic [7:0] bufData;
  logic       sdaIn, sclIn;
  int         cyc = 0;
  int         checks = 0, failures = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign sdaIn = !(sdaDriveLow || extSda);
  assign sclIn = !(sclDriveLow || extScl);

  i2cRestartGen u_dut (
    .clk(clk), .rstN(rstN), .reqWrite(reqWrite), .otherBusy(otherBusy),
    .bufWrite(bufWrite), .bufWData(bufWData), .reloadVal(reloadVal),
    .sdaIn(sdaIn), .sclIn(sclIn), .sdaDriveLow(sdaDriveLow), .sclDriveLow(sclDriveLow),
    .reqBit(reqBit), .startSeen(startSeen), .doneFlag(doneFlag), .collFlag(collFlag),
    .wrColl(wrColl), .bufData(bufData)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; reqWrite = 1'b0; bufWrite = 1'b0; otherBusy = 1'b0;
    extSda = 1'b0; extScl = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // raise request for one edge; returns cycle stamp of the accepting edge
  task automatic pulseReq(output int t0);
    reqWrite = 1'b1;
    @(negedge clk);
    reqWrite = 1'b0;
    t0 = cyc;
  endtask

  initial begin
    int t0;
    doReset();
    // R11 reset state
    check("R11 sdaDriveLow", sdaDriveLow, 0);
    check("R11 sclDriveLow", sclDriveLow, 0);
    check("R11 flags", {reqBit, startSeen, doneFlag, collFlag, wrColl}, 0);

    // R2 R4 R5 R6 sweep over reload values with free lines
    for (int n = 0; n <= 10; n++) begin
      int tDone, tStart;
      reloadVal = 7'(n);
      doReset();
      pulseReq(t0);
      check("R2 scl pulled at once", sclDriveLow, 1);
      check("R3 sda released while scl low", sdaDriveLow, 0);
      tDone = -1; tStart = -1;
      for (int k = 0; k < 120; k++) begin
        if (tStart < 0 && startSeen) tStart = cyc - t0;
        if (tDone < 0 && doneFlag)   tDone  = cyc - t0;
        @(negedge clk);
      end
      check("R5 done time", tDone, 3 * n + 9);
      check("R6 start time", tStart, 2 * n + 11);
      check("R5 sda held low", sdaDriveLow, 1);
      check("R5 reqBit cleared", reqBit, 0);
      check("R8 no collision", collFlag, 0);
    end

    // R5 held SDA released by next request, second run completes
    reloadVal = 7'd3;
    pulseReq(t0);
    check("R6 flags cleared on accept", {startSeen, doneFlag}, 0);
    repeat (60) @(negedge clk);
    check("R5 second run done", doneFlag, 1);

    // R1 request ignored while another event runs
    doReset();
    otherBusy = 1'b1;
    pulseReq(t0);
    otherBusy = 1'b0;
    repeat (6) @(negedge clk);
    check("R1 reqBit", reqBit, 0);
    check("R1 scl not driven", sclDriveLow, 0);

    // R3 SDA stretched low by the bus keeps SCL low
    doReset();
    reloadVal = 7'd4;
    extSda = 1'b1;
    repeat (4) @(negedge clk);
    pulseReq(t0);
    repeat (30) @(negedge clk);
    check("R3 scl still driven", sclDriveLow, 1);
    extSda = 1'b0;
    repeat (60) @(negedge clk);
    check("R3 done after release", doneFlag, 1);
    check("R3 no collision", collFlag, 0);

    // R7 R8 SCL pulled low during both-high phase
    doReset();
    reloadVal = 7'd6;
    pulseReq(t0);
    while (cyc - t0 < 14) @(negedge clk);
    extScl = 1'b1;
    repeat (10) @(negedge clk);
    extScl = 1'b0;
    check("R7 scl-low collision", collFlag, 1);
    check("R8 no done", doneFlag, 0);
    check("R8 req cleared", reqBit, 0);
    check("R8 lines released", {sdaDriveLow, sclDriveLow}, 0);

    // R7 R8 SDA low when SCL rises
    doReset();
    reloadVal = 7'd6;
    pulseReq(t0);
    while (cyc - t0 < 8) @(negedge clk);
    extScl = 1'b1;
    while (cyc - t0 < 12) @(negedge clk);
    extSda = 1'b1;
    while (cyc - t0 < 14) @(negedge clk);
    extScl = 1'b0;
    repeat (10) @(negedge clk);
    extSda = 1'b0;
    check("R7 sda-low collision", collFlag, 1);
    check("R8 no done", doneFlag, 0);
    check("R8 lines released", {sdaDriveLow, sclDriveLow}, 0);

    // R10 second request mid-sequence ignored
    doReset();
    reloadVal = 7'd5;
    pulseReq(t0);
    begin
      int tDone = -1;
      while (cyc - t0 < 10) @(negedge clk);
      pulseReq(tDone);
      tDone = -1;
      for (int k = 0; k < 60; k++) begin
        if (tDone < 0 && doneFlag) tDone = cyc - t0;
        @(negedge clk);
      end
      check("R10 done time unchanged", tDone, 24);
      check("R10 no second run", sclDriveLow, 0);
      check("R10 reqBit", reqBit, 0);
    end

    // R9 buffer writes
    doReset();
    bufWData = 8'hA5; bufWrite = 1'b1;
    @(negedge clk); bufWrite = 1'b0;
    check("R9 idle write stored", bufData, 8'hA5);
    check("R9 no wrColl idle", wrColl, 0);
    reloadVal = 7'd8;
    pulseReq(t0);
    repeat (4) @(negedge clk);
    bufWData = 8'h3C; bufWrite = 1'b1;
    @(negedge clk); bufWrite = 1'b0;
    check("R9 busy write dropped", bufData, 8'hA5);
    check("R9 wrColl set", wrColl, 1);
    repeat (60) @(negedge clk);
    bufWrite = 1'b1;
    @(negedge clk); bufWrite = 1'b0;
    check("R9 write after done", bufData, 8'h3C);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule